// File: doc/BRIEF.md
# Pipelined Bus Phase Sequencer

This block moves shared-bus transactions through their three phases in a fixed order: allocation of the bus to a master, then the address phase, then the data transfer. Transactions overlap, so the bus can be allocated for a later transaction while an earlier one is still addressing or moving data. The winner index of an external arbiter, with the transaction's address and write data, enters the allocation stage. The index travels with the transaction, so the owner shown at each later phase is always the master that won that transaction.

A mode input selects the depth of the overlap. In two-level mode (mode value 0) a transaction goes from allocation straight into one combined stage, where the address and data strobes are asserted together. In three-level mode (mode value 1) address and data each have their own stage, so three transactions can be in flight at once. A data phase stays on the bus until the slave signals ready, and any stage behind it that is full waits. A mode change is taken only when the pipeline is empty. Until then no new transaction is accepted.

Top module: `bps_phase_seq`

## Requirements
- R1: After reset all three stage valid flags and both strobes are low, `alloc_ready` is high and `mode_active` is 0 (two-level).
- R2: When `arb_valid` and `alloc_ready` are both high at a clock edge, the allocation stage is valid after that edge, and `arb_owner` equals the `arb_winner` that was sampled at the edge.
- R3: In three-level mode (`mode_active` = 1) a transaction moves from allocation to address to data, one stage per edge when it is not blocked. During the address stage `addr_strobe` is high and `bus_addr`/`addr_owner` carry that transaction's address and winner. During the data stage `data_strobe` is high and `bus_wdata` carries its data.
- R4: In two-level mode (`mode_active` = 0) a transaction goes from allocation directly into the combined stage, where `addr_strobe` and `data_strobe` are both high and `bus_addr`, `bus_wdata` and `data_owner` belong to that transaction. `addr_stg_valid` stays low.
- R5: When the slave is always ready and requests arrive back to back, one transaction completes per cycle. N transactions complete N+3 cycles after the first is offered in three-level mode, and N+2 cycles after in two-level mode. In three-level mode all three stages are valid at the same time.
- R6: A data phase completes only at an edge where `slave_ready` is high, and it holds its owner and data until then. A full stage whose successor cannot take it waits. `alloc_ready` is low while the allocation stage is full and cannot advance.
- R7: Transactions complete in the order they were accepted. At every stage the owner index is the winner that was captured when the transaction was allocated.
- R8: While `mode_req` differs from `mode_active`, `alloc_ready` is low. `mode_active` takes the value of `mode_req` only at an edge where all three stages are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Requested overlap mode: 0 two-level, 1 three-level |
| arb_valid | input | 1 | Arbiter presents a winner |
| arb_winner | input | OWN_W | Index of the winning master |
| req_addr | input | ADDR_W | Address of the offered transaction |
| req_wdata | input | DATA_W | Write data of the offered transaction |
| slave_ready | input | 1 | Slave finishes the current data phase |
| alloc_ready | output | 1 | Allocation stage can take a transaction this cycle |
| mode_active | output | 1 | Overlap mode in effect |
| arb_stg_valid | output | 1 | Allocation stage holds a transaction |
| addr_stg_valid | output | 1 | Separate address stage holds a transaction |
| data_stg_valid | output | 1 | Data (or combined) stage holds a transaction |
| arb_owner | output | OWN_W | Winner held in the allocation stage |
| addr_owner | output | OWN_W | Master driving the address phase |
| data_owner | output | OWN_W | Master driving the data phase |
| addr_strobe | output | 1 | Address phase active on the bus |
| data_strobe | output | 1 | Data phase active on the bus |
| bus_addr | output | ADDR_W | Address driven in the address phase |
| bus_wdata | output | DATA_W | Data driven in the data phase |

## Verification
The hardest condition to reach is a mode change requested while all three stages are full and the slave is stalling. The request must wait, and upstream acceptance must stay blocked while the pipeline drains one completion at a time. The stimulus gets there by holding `slave_ready` low until allocation, address and data are all occupied, then flipping `mode_req` with `arb_valid` still high, and only then releasing the slave. Sweeps over both modes and several ready duty patterns then exercise order, ownership and throughput.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic {
        MODE_TWO   = 1'b0,
        MODE_THREE = 1'b1
    } mode_t;

    localparam int NUM_STAGES = 3;
    localparam int STG_ARB    = 0;
    localparam int STG_ADDR   = 1;
    localparam int STG_DATA   = 2;

    typedef struct packed {
        mode_t mode;
    } ctl_t;
endpackage

// File: rtl/bps_stage.sv
module bps_stage #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             unload,
    input  logic [PAY_W-1:0] din,
    output logic             valid,
    output logic [PAY_W-1:0] payload
);
    typedef struct packed {
        logic             v;
        logic [PAY_W-1:0] pay;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.v   = 1'b1;
            s_d.pay = din;
        end else if (unload) begin
            s_d.v   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid   = s_q.v;
    assign payload = s_q.pay;
endmodule

// File: rtl/bps_flow_ctrl.sv
module bps_flow_ctrl (
    input  logic mode3,
    input  logic a_v,
    input  logic b_v,
    input  logic c_v,
    input  logic slave_ready,
    input  logic arb_valid,
    input  logic mode_pending,
    output logic c_done,
    output logic b_adv,
    output logic a_adv,
    output logic a_load,
    output logic c_load,
    output logic alloc_ready
);
    logic c_free, b_free, a_free;

    always_comb begin
        c_done      = c_v & slave_ready;
        c_free      = ~c_v | c_done;
        b_adv       = mode3 & b_v & c_free;
        b_free      = ~b_v | b_adv;
        a_adv       = a_v & (mode3 ? b_free : c_free);
        a_free      = ~a_v | a_adv;
        alloc_ready = a_free & ~mode_pending;
        a_load      = arb_valid & alloc_ready;
        c_load      = mode3 ? b_adv : a_adv;
    end
endmodule

// File: rtl/bps_phase_seq.sv
module bps_phase_seq
    import bps_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    localparam int OWN_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req,
    input  logic              arb_valid,
    input  logic [OWN_W-1:0]  arb_winner,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              slave_ready,
    output logic              alloc_ready,
    output logic              mode_active,
    output logic              arb_stg_valid,
    output logic              addr_stg_valid,
    output logic              data_stg_valid,
    output logic [OWN_W-1:0]  arb_owner,
    output logic [OWN_W-1:0]  addr_owner,
    output logic [OWN_W-1:0]  data_owner,
    output logic              addr_strobe,
    output logic              data_strobe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    localparam int PAY_W = OWN_W + ADDR_W + DATA_W;

    ctl_t ctl_d, ctl_q;
    logic mode3, mode_pending, pipe_empty;

    logic [NUM_STAGES-1:0] st_load, st_unload, st_v;
    logic [PAY_W-1:0]      st_din [NUM_STAGES];
    logic [PAY_W-1:0]      st_pay [NUM_STAGES];

    logic c_done, b_adv, a_adv, a_load, c_load;

    assign mode3        = (ctl_q.mode == MODE_THREE);
    assign mode_pending = (mode_t'(mode_req) != ctl_q.mode);
    assign pipe_empty   = ~|st_v;

    always_comb begin
        ctl_d = ctl_q;
        if (mode_pending && pipe_empty) ctl_d.mode = mode_t'(mode_req);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{mode: MODE_TWO};
        else        ctl_q <= ctl_d;
    end

    bps_flow_ctrl u_flow (
        .mode3       (mode3),
        .a_v         (st_v[STG_ARB]),
        .b_v         (st_v[STG_ADDR]),
        .c_v         (st_v[STG_DATA]),
        .slave_ready (slave_ready),
        .arb_valid   (arb_valid),
        .mode_pending(mode_pending),
        .c_done      (c_done),
        .b_adv       (b_adv),
        .a_adv       (a_adv),
        .a_load      (a_load),
        .c_load      (c_load),
        .alloc_ready (alloc_ready)
    );

    assign st_load   = {c_load, mode3 & a_adv, a_load};
    assign st_unload = {c_done, b_adv, a_adv};

    assign st_din[STG_ARB]  = {arb_winner, req_addr, req_wdata};
    assign st_din[STG_ADDR] = st_pay[STG_ARB];
    assign st_din[STG_DATA] = mode3 ? st_pay[STG_ADDR] : st_pay[STG_ARB];

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        bps_stage #(.PAY_W(PAY_W)) u_stg (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (st_load[g]),
            .unload (st_unload[g]),
            .din    (st_din[g]),
            .valid  (st_v[g]),
            .payload(st_pay[g])
        );
    end

    // Address phase comes from the separate stage or the combined stage
    logic [PAY_W-1:0] addr_pay;
    assign addr_pay = mode3 ? st_pay[STG_ADDR] : st_pay[STG_DATA];

    assign mode_active    = ctl_q.mode;
    assign arb_stg_valid  = st_v[STG_ARB];
    assign addr_stg_valid = st_v[STG_ADDR];
    assign data_stg_valid = st_v[STG_DATA];
    assign arb_owner      = st_pay[STG_ARB][PAY_W-1 -: OWN_W];
    assign addr_owner     = addr_pay[PAY_W-1 -: OWN_W];
    assign data_owner     = st_pay[STG_DATA][PAY_W-1 -: OWN_W];
    assign addr_strobe    = mode3 ? st_v[STG_ADDR] : st_v[STG_DATA];
    assign data_strobe    = st_v[STG_DATA];
    assign bus_addr       = addr_pay[DATA_W +: ADDR_W];
    assign bus_wdata      = st_pay[STG_DATA][DATA_W-1:0];

    // R2: accepted winner appears in the allocation stage
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid && alloc_ready |=> arb_stg_valid && arb_owner == $past(arb_winner));

    // R6: data phase holds owner and data while the slave stalls
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        data_stg_valid && !slave_ready |=>
            data_stg_valid && $stable(data_owner) && $stable(bus_wdata));

    // R7: the address-phase owner is the one that takes the data phase
    a_r7_owner_carry: assert property (@(posedge clk) disable iff (!rst_n)
        mode3 && addr_stg_valid && (!data_stg_valid || slave_ready) |=>
            data_stg_valid && data_owner == $past(addr_owner));

    // R4: no separate address stage in two-level mode
    a_r4_no_addr_stage: assert property (@(posedge clk) disable iff (!rst_n)
        !mode3 |-> !addr_stg_valid);

    // R8: the active mode changes only from an empty pipeline
    a_r8_mode_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active != $past(mode_active)) |->
            $past(!arb_stg_valid && !addr_stg_valid && !data_stg_valid));

    // R8: no acceptance while a mode change waits
    a_r8_block_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req != mode_active) |-> !alloc_ready);
endmodule

// File: tb/tb_bps_phase_seq.sv
module tb_bps_phase_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NM = 4;
    localparam int OW = 2;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_req;
    logic          arb_valid;
    logic [OW-1:0] arb_winner;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          slave_ready;
    logic          alloc_ready, mode_active;
    logic          arb_stg_valid, addr_stg_valid, data_stg_valid;
    logic [OW-1:0] arb_owner, addr_owner, data_owner;
    logic          addr_strobe, data_strobe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bps_phase_seq #(.NUM_MASTERS(NM), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

    function automatic logic [OW-1:0] w_of(int k);
        return OW'(k % NM);
    endfunction
    function automatic logic [AW-1:0] a_of(int k);
        return AW'(k * 37 + 5);
    endfunction
    function automatic logic [DW-1:0] d_of(int k);
        return DW'((k * 91) ^ 16'hA5A5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_reset(input bit m);
        rst_n = 1'b0; mode_req = m; arb_valid = 1'b0; slave_ready = 1'b0;
        arb_winner = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Stream n transactions; slave ready one cycle in every gap+1
    task automatic run_stream(input bit m3, input int n, input int gap);
        int issued = 0, done = 0, cyc = 0, ib, ia;
        bit full_seen = 0;
        chk(mode_active == m3, "R8 mode set", mode_active, m3);
        while (done < n && cyc < 400) begin
            @(negedge clk);
            slave_ready = ((cyc % (gap + 1)) == gap);
            arb_valid   = (issued < n);
            arb_winner  = w_of(issued);
            req_addr    = a_of(issued);
            req_wdata   = d_of(issued);
            #1;
            ib = done + int'(data_strobe);
            ia = ib + int'(addr_stg_valid);
            if (data_strobe) begin
                chk(data_owner == w_of(done), "R7 data owner", data_owner, w_of(done));
                chk(bus_wdata == d_of(done), "R3 R4 data", bus_wdata, d_of(done));
            end
            if (m3 && addr_stg_valid) begin
                chk(addr_strobe, "R3 addr strobe", addr_strobe, 1);
                chk(bus_addr == a_of(ib), "R3 address", bus_addr, a_of(ib));
                chk(addr_owner == w_of(ib), "R7 addr owner", addr_owner, w_of(ib));
            end
            if (!m3) begin
                chk(!addr_stg_valid, "R4 no addr stage", addr_stg_valid, 0);
                chk(addr_strobe == data_strobe, "R4 combined", addr_strobe, data_strobe);
                if (data_strobe)
                    chk(bus_addr == a_of(done), "R4 address", bus_addr, a_of(done));
            end
            if (arb_stg_valid)
                chk(arb_owner == w_of(ia), "R2 arb owner", arb_owner, w_of(ia));
            if (arb_stg_valid && addr_stg_valid && data_stg_valid) full_seen = 1;
            if (data_strobe && slave_ready) done++;
            if (arb_valid && alloc_ready) issued++;
            cyc++;
        end
        @(negedge clk);
        arb_valid = 1'b0;
        slave_ready = 1'b0;
        chk(done == n, "R7 all completed", done, n);
        if (gap == 0) begin
            chk(cyc == n + (m3 ? 3 : 2), "R5 latency", cyc, n + (m3 ? 3 : 2));
            if (m3) chk(full_seen, "R5 three in flight", full_seen, 1);
        end
    endtask

    initial begin
        #(200000 * 10);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        bit prev_empty;
        int guard;
        // R1 reset state
        do_reset(1'b0);
        chk(!arb_stg_valid && !addr_stg_valid && !data_stg_valid, "R1 stages empty",
            {arb_stg_valid, addr_stg_valid, data_stg_valid}, 0);
        chk(!addr_strobe && !data_strobe, "R1 strobes low", {addr_strobe, data_strobe}, 0);
        chk(alloc_ready, "R1 alloc ready", alloc_ready, 1);
        chk(mode_active == 1'b0, "R1 mode", mode_active, 0);

        // Sweep modes and ready patterns
        for (int m = 0; m < 2; m++) begin
            for (int gap = 0; gap < 4; gap++) begin
                do_reset(m[0]);
                run_stream(m[0], 6, gap);
            end
        end

        // R6 fill three-level pipeline with the slave stalled
        do_reset(1'b1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            slave_ready = 1'b0;
            arb_valid = 1'b1;
            arb_winner = w_of(k >= 3 ? 3 : k);
            req_addr = a_of(k >= 3 ? 3 : k);
            req_wdata = d_of(k >= 3 ? 3 : k);
            if (k < 3) arb_winner = w_of(k);
        end
        #1;
        chk(arb_stg_valid && addr_stg_valid && data_stg_valid, "R6 all full",
            {arb_stg_valid, addr_stg_valid, data_stg_valid}, 7);
        chk(!alloc_ready, "R6 alloc blocked", alloc_ready, 0);
        chk(data_owner == w_of(0), "R6 data held", data_owner, w_of(0));
        chk(addr_owner == w_of(1), "R6 addr held", addr_owner, w_of(1));
        chk(arb_owner == w_of(2), "R6 arb held", arb_owner, w_of(2));
        chk(bus_wdata == d_of(0), "R6 wdata held", bus_wdata, d_of(0));

        // R8 mode change requested while full
        @(negedge clk);
        mode_req = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(mode_active == 1'b1, "R8 mode waits", mode_active, 1);
        chk(!alloc_ready, "R8 accept blocked", alloc_ready, 0);
        prev_empty = 0;
        guard = 0;
        @(negedge clk);
        slave_ready = 1'b1;
        while (mode_active == 1'b1 && guard < 20) begin
            prev_empty = !arb_stg_valid && !addr_stg_valid && !data_stg_valid;
            #1;
            chk(!alloc_ready, "R8 blocked while pending", alloc_ready, 0);
            @(negedge clk);
            guard++;
        end
        #1;
        chk(mode_active == 1'b0, "R8 mode switched", mode_active, 0);
        chk(prev_empty, "R8 switched from empty", prev_empty, 1);
        chk(!arb_stg_valid, "R8 nothing accepted early", arb_stg_valid, 0);
        chk(alloc_ready, "R8 accept resumes", alloc_ready, 1);
        @(negedge clk);
        #1;
        chk(arb_stg_valid && arb_owner == w_of(3), "R2 accept after switch", arb_owner, w_of(3));

        // R1 reset in mid-activity
        do_reset(1'b0);
        chk(!data_strobe && !arb_stg_valid, "R1 reset clears", {data_strobe, arb_stg_valid}, 0);

        finish_run();
    end
endmodule